// File: doc/BRIEF.md
# Locked Configuration Register Port

This block is the configuration front end of a multi-function I/O controller. A host reaches it through two adjacent byte addresses on a simple synchronous I/O bus: an index port and a data port. After reset the port is locked. It opens only after the host writes a fixed four-byte key to the index port. While it is open, the host first writes a register number to the index port. It then reads or writes that register through the data port.

The register space is split into two kinds. Global registers are the device-select register, the read-only 16-bit identity (high byte first), the revision and a control register. Writing the lock bit of the control register closes the port again. A window of banked registers is stored separately for each function number chosen through the device-select register. One banked register pair of one chosen function is also driven out as a 16-bit runtime base address, so that other logic on the chip can decode that function's registers.

Top module: `sio_cfg_port`

## Requirements
- R1: The index port is at address IO_BASE (default 0x002E) and the data port at IO_BASE+1. A read or write at any other address has no effect and gives no read response.
- R2: The port opens (cfg_open=1) only after the bytes 0x87, 0x01, 0x55, 0x55 are written to the index port in that order. cfg_open rises on the clock edge that takes the fourth byte.
- R3: A wrong byte during the key restarts the key detector. If the wrong byte is 0x87, it counts as the first byte of a new attempt.
- R4: While the port is locked, reads of either port return 0xFF, data-port writes change no register, and index-port writes do not change the latched index.
- R5: While the port is open, an index-port write latches the register number, and an index-port read returns it.
- R6: Index 0x20 reads CHIP_ID[15:8], index 0x21 reads CHIP_ID[7:0] and index 0x22 reads the revision in bits 3:0 with bits 7:4 zero. Writes to these indices are ignored.
- R7: Index 0x07 is the read/write function select. Banked indices (BANK_LO to BANK_LO+BANK_N-1, default 0x30 to 0x6F) are stored separately for each function number below NUM_LDN. For other function numbers, banked indices read 0x00 and writes to them are ignored.
- R8: Indices 0x20 to 0x2F read the same values whatever function is selected.
- R9: A data write to index 0x02 with bit 1 set locks the port and resets the function select and the index to 0. A write to index 0x02 with bit 1 clear leaves the port open.
- R10: rt_base is {bank[FUNC_LDN][RTB_IDX], bank[FUNC_LDN][RTB_IDX+1]} (default function 7, indices 0x62/0x63, high byte first). It updates on the edge that takes the write. Banked contents survive locking.
- R11: A read accepted on a clock edge presents io_rdata with io_rvalid=1 in the following cycle only.
- R12: After reset the port is locked, the function select is 0, all banked registers are 0 and io_rvalid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Bus address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rvalid is 1 |
| io_rvalid | output | 1 | Read response strobe |
| cfg_open | output | 1 | Configuration port is unlocked |
| rt_base | output | 16 | Runtime base address of the selected function |

## Verification
A read strobe taken on an edge is answered by io_rvalid and io_rdata exactly one cycle later. The bench pushes each expected byte into a queue when it drives the read. The monitor pops that byte when it sees io_rvalid at the falling edge, and a response that appears with nothing queued counts as a failure. cfg_open and rt_base change on the same edge that takes the fourth key byte, the lock write or the register write. The bench therefore samples them at the falling edge that follows the strobe.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam logic [7:0] IDX_CTRL   = 8'h02;
   localparam logic [7:0] IDX_FSEL   = 8'h07;
   localparam logic [7:0] IDX_ID_HI  = 8'h20;
   localparam logic [7:0] IDX_ID_LO  = 8'h21;
   localparam logic [7:0] IDX_REV    = 8'h22;
   localparam logic [7:0] GLOB_HI    = 8'h2F;
   localparam int         LOCK_BIT   = 1;
   localparam logic [7:0] LOCKED_RD  = 8'hFF;

   typedef enum logic [1:0] {
      PORT_NONE = 2'd0,
      PORT_IDX  = 2'd1,
      PORT_DATA = 2'd2
   } port_e;

   function automatic logic [7:0] key_byte(input logic [31:0] key, input logic [1:0] pos);
      return key[31 - 8*pos -: 8];
   endfunction
endpackage

// File: rtl/sio_key_detect.sv
module sio_key_detect #(
   parameter logic [31:0] KEY = 32'h8701_5555
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       locked,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       key_hit
);
   import sio_cfg_pkg::*;

   logic [1:0] pos_q;
   logic [7:0] want;
   logic       match;

   assign want    = key_byte(KEY, pos_q);
   assign match   = (wdata == want);
   assign key_hit = locked && idx_wr && match && (pos_q == 2'd3);

   always_ff @(posedge clk) begin
      if (!rst_n || !locked) begin
         pos_q <= 2'd0;
      end else if (idx_wr) begin
         if (match)
            pos_q <= pos_q + 2'd1;
         else if (wdata == key_byte(KEY, 2'd0))
            pos_q <= 2'd1;
         else
            pos_q <= 2'd0;
      end
   end
endmodule

// File: rtl/sio_cfg_glob.sv
module sio_cfg_glob (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_hit,
   input  logic       idx_wr,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   output logic       cfg_open,
   output logic [7:0] cur_idx,
   output logic [7:0] cur_fsel
);
   import sio_cfg_pkg::*;

   logic lock_now;

   assign lock_now = cfg_open && data_wr && (cur_idx == IDX_CTRL) && wdata[LOCK_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_open <= 1'b0;
         cur_idx  <= 8'h00;
         cur_fsel <= 8'h00;
      end else begin
         if (key_hit)
            cfg_open <= 1'b1;
         else if (lock_now)
            cfg_open <= 1'b0;

         if (lock_now)
            cur_idx <= 8'h00;
         else if (cfg_open && idx_wr)
            cur_idx <= wdata;

         if (lock_now)
            cur_fsel <= 8'h00;
         else if (cfg_open && data_wr && cur_idx == IDX_FSEL)
            cur_fsel <= wdata;
      end
   end
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank #(
   parameter int NUM_LDN  = 8,
   parameter int BANK_N   = 64,
   parameter int FUNC_LDN = 7,
   parameter int RTB_OFF  = 50,
   localparam int LDN_W   = $clog2(NUM_LDN),
   localparam int OFF_W   = $clog2(BANK_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LDN_W-1:0] sel_ldn,
   input  logic [OFF_W-1:0] sel_off,
   input  logic [7:0]       wdata,
   output logic [7:0]       rd_data,
   output logic [15:0]      rtb
);
   logic [7:0] row_rd [NUM_LDN];

   for (genvar l = 0; l < NUM_LDN; l++) begin : g_row
      logic [7:0] cells [BANK_N];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int o = 0; o < BANK_N; o++) cells[o] <= 8'h00;
         end else if (wr_en && sel_ldn == LDN_W'(l)) begin
            cells[sel_off] <= wdata;
         end
      end

      assign row_rd[l] = cells[sel_off];

      if (l == FUNC_LDN) begin : g_rtb
         assign rtb = {cells[RTB_OFF], cells[RTB_OFF+1]};
      end
   end

   assign rd_data = row_rd[sel_ldn];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
   parameter int              ADDR_W   = 16,
   parameter logic [15:0]     IO_BASE  = 16'h002E,
   parameter logic [31:0]     KEY      = 32'h8701_5555,
   parameter logic [15:0]     CHIP_ID  = 16'h8728,
   parameter logic [3:0]      CHIP_REV = 4'h2,
   parameter int              NUM_LDN  = 8,
   parameter int              BANK_LO  = 'h30,
   parameter int              BANK_N   = 64,
   parameter int              FUNC_LDN = 7,
   parameter int              RTB_IDX  = 'h62
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              io_rvalid,
   output logic              cfg_open,
   output logic [15:0]       rt_base
);
   import sio_cfg_pkg::*;

   localparam int LDN_W    = $clog2(NUM_LDN);
   localparam int OFF_W    = $clog2(BANK_N);
   localparam int BANK_END = BANK_LO + BANK_N;
   localparam int RTB_OFF  = RTB_IDX - BANK_LO;
   localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(IO_BASE);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(IO_BASE) + ADDR_W'(1);

   if (NUM_LDN < 2 || (1 << LDN_W) != NUM_LDN) begin : g_bad_ldn
      $error("NUM_LDN must be a power of two of at least 2");
   end
   if (BANK_N < 2 || (1 << OFF_W) != BANK_N) begin : g_bad_bank
      $error("BANK_N must be a power of two of at least 2");
   end
   if (BANK_LO <= int'(GLOB_HI) || BANK_END > 256) begin : g_bad_win
      $error("banked window must lie above the global indices and below 0x100");
   end
   if (RTB_IDX < BANK_LO || RTB_IDX + 1 >= BANK_END) begin : g_bad_rtb
      $error("runtime base pair must lie inside the banked window");
   end
   if (FUNC_LDN >= NUM_LDN || FUNC_LDN < 0) begin : g_bad_func
      $error("FUNC_LDN out of range");
   end
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W must be between 2 and 16");
   end

   port_e      port;
   logic       idx_wr, data_wr;
   logic       key_hit;
   logic [7:0] cur_idx, cur_fsel;
   logic       in_bank, fsel_ok, bank_wr;
   logic [7:0] bank_sub;
   logic [OFF_W-1:0] bank_off;
   logic [7:0] bank_rd;
   logic [7:0] data_val, rd_val;

   always_comb begin
      if (io_addr == A_IDX)       port = PORT_IDX;
      else if (io_addr == A_DATA) port = PORT_DATA;
      else                        port = PORT_NONE;
   end

   assign idx_wr  = io_wr && (port == PORT_IDX);
   assign data_wr = io_wr && (port == PORT_DATA);

   sio_key_detect #(.KEY(KEY)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .locked  (!cfg_open),
      .idx_wr  (idx_wr),
      .wdata   (io_wdata),
      .key_hit (key_hit)
   );

   sio_cfg_glob u_glob (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_hit  (key_hit),
      .idx_wr   (idx_wr),
      .data_wr  (data_wr),
      .wdata    (io_wdata),
      .cfg_open (cfg_open),
      .cur_idx  (cur_idx),
      .cur_fsel (cur_fsel)
   );

   assign in_bank  = (int'(cur_idx) >= BANK_LO) && (int'(cur_idx) < BANK_END);
   assign fsel_ok  = int'(cur_fsel) < NUM_LDN;
   assign bank_sub = cur_idx - 8'(BANK_LO);
   assign bank_off = bank_sub[OFF_W-1:0];
   assign bank_wr  = cfg_open && data_wr && in_bank && fsel_ok;

   sio_cfg_bank #(
      .NUM_LDN  (NUM_LDN),
      .BANK_N   (BANK_N),
      .FUNC_LDN (FUNC_LDN),
      .RTB_OFF  (RTB_OFF)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .sel_ldn (cur_fsel[LDN_W-1:0]),
      .sel_off (bank_off),
      .wdata   (io_wdata),
      .rd_data (bank_rd),
      .rtb     (rt_base)
   );

   always_comb begin
      if (cur_idx == IDX_FSEL)           data_val = cur_fsel;
      else if (cur_idx == IDX_ID_HI)     data_val = CHIP_ID[15:8];
      else if (cur_idx == IDX_ID_LO)     data_val = CHIP_ID[7:0];
      else if (cur_idx == IDX_REV)       data_val = {4'h0, CHIP_REV};
      else if (in_bank && fsel_ok)       data_val = bank_rd;
      else                               data_val = 8'h00;
   end

   always_comb begin
      if (!cfg_open)               rd_val = LOCKED_RD;
      else if (port == PORT_IDX)   rd_val = cur_idx;
      else                         rd_val = data_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_rvalid <= 1'b0;
         io_rdata  <= 8'h00;
      end else begin
         io_rvalid <= io_rd && (port != PORT_NONE);
         if (io_rd && port != PORT_NONE)
            io_rdata <= rd_val;
      end
   end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
   parameter int          ADDR_W  = 16,
   parameter logic [15:0] IO_BASE = 16'h002E,
   parameter logic [15:0] CHIP_ID = 16'h8728
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              io_rvalid,
   input logic              cfg_open,
   input logic [7:0]        cur_idx,
   input logic [7:0]        cur_fsel
);
   localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(IO_BASE);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(IO_BASE) + ADDR_W'(1);

   logic hit;
   assign hit = (io_addr == A_IDX) || (io_addr == A_DATA);

   a_r11_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && hit) |=> io_rvalid);

   a_r1_no_resp_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && hit) |=> !io_rvalid);

   a_r4_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && hit && !cfg_open) |=> (io_rdata == 8'hFF));

   a_r2_open_on_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(io_wr && io_addr == A_IDX && io_wdata == 8'h55));

   a_r9_lock_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && io_wr && io_addr == A_DATA && cur_idx == 8'h02 && io_wdata[1]) |=> !cfg_open);

   a_r9_fsel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_open) |-> (cur_fsel == 8'h00 && cur_idx == 8'h00));

   a_r6_id_high: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == A_DATA && cfg_open && cur_idx == 8'h20) |=> (io_rdata == CHIP_ID[15:8]));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
   .ADDR_W  (ADDR_W),
   .IO_BASE (IO_BASE),
   .CHIP_ID (CHIP_ID)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_addr   (io_addr),
   .io_wr     (io_wr),
   .io_rd     (io_rd),
   .io_wdata  (io_wdata),
   .io_rdata  (io_rdata),
   .io_rvalid (io_rvalid),
   .cfg_open  (cfg_open),
   .cur_idx   (cur_idx),
   .cur_fsel  (cur_fsel)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/100ps
module sim_sio_cfg_port;
   localparam logic [15:0] P_IDX  = 16'h002E;
   localparam logic [15:0] P_DATA = 16'h002F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0000;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic        io_rvalid;
   logic        cfg_open;
   logic [15:0] rt_base;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   sio_cfg_port u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
      .cfg_open(cfg_open), .rt_base(rt_base)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: R11 a response appears exactly one cycle after its strobe
   always @(negedge clk) begin
      if (rst_n && io_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R1/R11: actual=rvalid with data %0h expected=no response", io_rdata);
         end else begin
            check(tag_q.pop_front(), {24'h0, io_rdata}, {24'h0, exp_q.pop_front()});
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic unlock();
      wr(P_IDX, 8'h87); wr(P_IDX, 8'h01); wr(P_IDX, 8'h55); wr(P_IDX, 8'h55);
   endtask

   task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
      wr(P_IDX, idx); wr(P_DATA, d);
   endtask

   task automatic reg_rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
      wr(P_IDX, idx); rd(P_DATA, exp, tag);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 open after reset", cfg_open, 0);
      check("R12 rvalid after reset", io_rvalid, 0);
      check("R12 rt_base after reset", rt_base, 0);

      rd(P_DATA, 8'hFF, "R4 locked data read");
      rd(P_IDX, 8'hFF, "R4 locked index read");
      rd(16'h0080, 8'h00, "unused");
      void'(exp_q.pop_back()); void'(tag_q.pop_back());
      @(negedge clk);
      check("R1 no response elsewhere", io_rvalid, 0);
      wr(16'h0030, 8'h87); wr(P_IDX, 8'h01); wr(P_IDX, 8'h55); wr(P_IDX, 8'h55);
      check("R1 key on wrong address", cfg_open, 0);

      wr(P_IDX, 8'h87); wr(P_IDX, 8'h01); wr(P_IDX, 8'h55); wr(P_IDX, 8'hAA);
      check("R3 wrong byte keeps locked", cfg_open, 0);
      wr(P_IDX, 8'h55);
      check("R3 stray byte after restart", cfg_open, 0);
      wr(P_IDX, 8'h87); wr(P_IDX, 8'h87); wr(P_IDX, 8'h01); wr(P_IDX, 8'h55);
      check("R2 three bytes not enough", cfg_open, 0);
      wr(P_IDX, 8'h55);
      check("R2 R3 open after key with repeated first byte", cfg_open, 1);

      wr(P_IDX, 8'h21);
      rd(P_IDX, 8'h21, "R5 index readback");
      reg_rd(8'h20, 8'h87, "R6 id high");
      reg_rd(8'h21, 8'h28, "R6 id low");
      reg_rd(8'h22, 8'h02, "R6 revision");
      reg_wr(8'h20, 8'h11);
      reg_rd(8'h20, 8'h87, "R6 id write ignored");

      reg_wr(8'h07, 8'h07);
      reg_rd(8'h07, 8'h07, "R7 select readback");
      wr(P_IDX, 8'h62); wr(P_DATA, 8'h0A);
      check("R10 rt_base high byte", rt_base, 16'h0A00);
      reg_wr(8'h63, 8'h20);
      check("R10 rt_base both bytes", rt_base, 16'h0A20);
      reg_wr(8'h07, 8'h03);
      reg_wr(8'h62, 8'h55);
      reg_rd(8'h62, 8'h55, "R7 bank of function 3");
      check("R7 other bank leaves rt_base", rt_base, 16'h0A20);
      reg_rd(8'h21, 8'h28, "R8 global with function 3");
      reg_wr(8'h07, 8'h07);
      reg_rd(8'h62, 8'h0A, "R7 bank of function 7 kept");
      reg_wr(8'h07, 8'h10);
      reg_wr(8'h62, 8'h33);
      reg_rd(8'h62, 8'h00, "R7 out-of-range function");
      reg_rd(8'h20, 8'h87, "R8 global with function 0x10");
      reg_wr(8'h07, 8'h07);
      reg_rd(8'h62, 8'h0A, "R7 write to out-of-range ignored");

      reg_wr(8'h02, 8'h00);
      check("R9 clear bit keeps open", cfg_open, 1);
      wr(P_IDX, 8'h02); wr(P_DATA, 8'h02);
      check("R9 lock bit closes", cfg_open, 0);
      rd(P_DATA, 8'hFF, "R9 R4 data read after lock");
      check("R10 rt_base kept after lock", rt_base, 16'h0A20);
      wr(P_IDX, 8'h07); wr(P_DATA, 8'h05);
      unlock();
      check("R2 reopen", cfg_open, 1);
      rd(P_IDX, 8'h00, "R9 R4 index cleared and locked write ignored");
      reg_rd(8'h07, 8'h00, "R9 R4 select cleared, locked write ignored");
      reg_rd(8'h62, 8'h00, "R9 function 0 bank empty");

      repeat (4) @(negedge clk);
      check("R11 all responses arrived", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule